// File: doc/BRIEF.md
# Frame Marker Sequence Monitor

This block watches a packet stream from the side and does not touch it. The stream's framing is carried on four per-cycle marker strobes and one beat qualifier. The marker strobes are frame start, IP-packet start, payload start and frame end. The qualifier is beat enable. A small sequencer tracks where each frame has reached in its normal progression. When a cycle's markers break that progression, the monitor records the event. A single bad cycle is one kind of event. A bad ordering spread over many cycles is another, for example a second payload start inside the same frame.

On the first violation a sticky trigger output rises, and a 3-bit code names the rule that broke. Both hold until a clear pulse. A saturating counter tallies every violation, including those that come after the trigger has fired. After any violation the sequencer drops the current frame. It then ignores the stream until a clean frame start arrives. The outputs are meant for an on-chip debug trigger or for an error collector next to the datapath.

Top module: `frame_seq_monitor`

## Requirements
- R1: After reset, trig_o is 0, trig_code_o is 0, viol_count_o is 0 and frame_open_o is 0.
- R2: A frame is legal when each of its markers arrives alone, in a cycle with beat_en_i high, in the order frame start, IP start, payload start, frame end. Cycles with no marker may fall between them, whatever the level of beat_en_i. frame_open_o is 1 from the cycle after frame start up to and including the cycle of frame end, and legal frames raise no violation.
- R3: Any marker that arrives with beat_en_i low is a violation with code 1. This rule takes priority over every other rule.
- R4: Two or more markers in the same cycle with beat_en_i high is a violation with code 2. This rule takes priority over rules R5 to R9.
- R5: A frame start while a frame is open is a violation with code 3.
- R6: An IP start, payload start or frame end while no frame is open is a violation with code 4.
- R7: A second payload start inside one frame is a violation with code 5.
- R8: A frame end before that frame's payload start is a violation with code 6.
- R9: Each of the following is a violation with code 7: an IP start that repeats or comes after payload start, and a payload start that comes before IP start.
- R10: trig_o rises in the cycle after the first violation, and trig_code_o takes that violation's code. Both then hold, unchanged by later violations, until clr_i.
- R11: viol_count_o goes up by 1 in the cycle after each violation and stops at 65535. clr_i does not reset it.
- R12: A violation closes the frame. From then on every marker is ignored and counts as no violation, until a frame start arrives alone with beat_en_i high. That frame start opens a new frame.
- R13: clr_i drops trig_o and trig_code_o to 0 and returns the sequencer to the no-frame state. The markers present in a clr_i cycle are not evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears trigger and code, returns the sequencer to no-frame |
| frm_start_i | input | 1 | Frame start marker |
| ip_start_i | input | 1 | IP-packet start marker |
| pay_start_i | input | 1 | Payload start marker |
| frm_end_i | input | 1 | Frame end marker |
| beat_en_i | input | 1 | Beat qualifier for the cycle |
| trig_o | output | 1 | Sticky violation trigger |
| trig_code_o | output | 3 | Code of the first violation since the last clear |
| viol_count_o | output | 16 | Saturating count of all violations |
| frame_open_o | output | 1 | A frame is in progress |

## Verification
The bench targets the priority between the cycle-level rules and the ordering rules. A design that checks ordering first would report code 3 or 7 where code 1 or 2 belongs. It drives violations while the trigger is already set, which catches a code that gets overwritten or a count that stops after the first event. It feeds junk during resynchronisation, where a design that forgets the resync state would count spurious violations, or would open a frame on a qualified-low or multi-marker start. It also runs the counter into saturation, where a wrapping counter would fall back to 0, and sends a clear in the same cycle as a bad marker, which must not be counted.

// File: rtl/fmon_pkg.sv
`timescale 1ns/1ps
package fmon_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GOT_SOF = 3'd1,
    ST_GOT_IP  = 3'd2,
    ST_PAYLOAD = 3'd3,
    ST_RESYNC  = 3'd4
  } seq_state_t;

  typedef enum logic [CODE_W-1:0] {
    V_NONE      = 3'd0,
    V_NO_BEAT   = 3'd1,
    V_MULTI     = 3'd2,
    V_REOPEN    = 3'd3,
    V_OUTSIDE   = 3'd4,
    V_DUP_PAY   = 3'd5,
    V_EARLY_END = 3'd6,
    V_ORDER     = 3'd7
  } viol_t;

  typedef struct packed {
    logic fstart;
    logic ipstart;
    logic pstart;
    logic fend;
  } marks_t;

  // Rule for a single qualified marker, given the current progress step.
  function automatic viol_t judge_single(seq_state_t st, marks_t m);
    viol_t v;
    v = V_NONE;
    case (st)
      ST_IDLE:    v = m.fstart  ? V_NONE : V_OUTSIDE;
      ST_GOT_SOF: v = m.ipstart ? V_NONE : m.fstart ? V_REOPEN :
                      m.fend    ? V_EARLY_END : V_ORDER;
      ST_GOT_IP:  v = m.pstart  ? V_NONE : m.fstart ? V_REOPEN :
                      m.fend    ? V_EARLY_END : V_ORDER;
      ST_PAYLOAD: v = m.fend    ? V_NONE : m.fstart ? V_REOPEN :
                      m.pstart  ? V_DUP_PAY : V_ORDER;
      default:    v = V_NONE;
    endcase
    return v;
  endfunction

  // Next step on a legal marker.
  function automatic seq_state_t advance(seq_state_t st);
    seq_state_t n;
    case (st)
      ST_IDLE:    n = ST_GOT_SOF;
      ST_GOT_SOF: n = ST_GOT_IP;
      ST_GOT_IP:  n = ST_PAYLOAD;
      default:    n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic is_open(seq_state_t st);
    return (st == ST_GOT_SOF) || (st == ST_GOT_IP) || (st == ST_PAYLOAD);
  endfunction

endpackage

// File: rtl/fmon_qual.sv
`timescale 1ns/1ps
module fmon_qual
  import fmon_pkg::*;
(
  input  marks_t marks,
  input  logic   beat_en,
  output logic   any_mark,
  output logic   multi_mark,
  output logic   unqualified
);
  logic [2:0] n_marks;

  always_comb begin
    n_marks = 3'(marks.fstart) + 3'(marks.ipstart) + 3'(marks.pstart) + 3'(marks.fend);
  end

  assign any_mark    = (n_marks != 3'd0);
  assign multi_mark  = (n_marks > 3'd1);
  assign unqualified = any_mark && !beat_en;
endmodule

// File: rtl/fmon_seq.sv
`timescale 1ns/1ps
module fmon_seq
  import fmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  marks_t     marks,
  input  logic       beat_en,
  input  logic       any_mark,
  input  logic       multi_mark,
  input  logic       unqualified,
  output seq_state_t state_o,
  output viol_t      viol_o
);
  seq_state_t st, st_nx;
  viol_t      v;

  always_comb begin
    v     = V_NONE;
    st_nx = st;
    if (clr) begin
      st_nx = ST_IDLE;
    end else if (st == ST_RESYNC) begin
      if (marks.fstart && beat_en && !multi_mark) st_nx = ST_GOT_SOF;
    end else if (any_mark) begin
      if (unqualified)     v = V_NO_BEAT;
      else if (multi_mark) v = V_MULTI;
      else                 v = judge_single(st, marks);
      st_nx = (v == V_NONE) ? advance(st) : ST_RESYNC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign state_o = st;
  assign viol_o  = v;

  // A legal frame end always closes back to no-frame.
  assert_end_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAYLOAD && marks.fend && beat_en && !multi_mark && !clr) |=> (st == ST_IDLE))
    else $error("frame end did not close frame");
endmodule

// File: rtl/fmon_trig.sv
`timescale 1ns/1ps
module fmon_trig
  import fmon_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  viol_t               viol,
  output logic                trig_o,
  output logic [CODE_W-1:0]   code_o
);
  logic              trig_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      code_q <= '0;
    end else if (clr) begin
      trig_q <= 1'b0;
      code_q <= '0;
    end else if (viol != V_NONE && !trig_q) begin
      trig_q <= 1'b1;
      code_q <= viol;
    end
  end

  assign trig_o = trig_q;
  assign code_o = code_q;

  assert_sticky_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !clr) |=> (trig_q && $stable(code_q)))
    else $error("trigger or code changed without clear");

  assert_code_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> (code_q != 3'd0))
    else $error("trigger rose with empty code");
endmodule

// File: rtl/fmon_count.sv
`timescale 1ns/1ps
module fmon_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_step(logic [W-1:0] c);
    return (c == TOP) ? c : c + 1'b1;
  endfunction

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= sat_step(cnt);
  end

  assign count_o = cnt;

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != TOP) |=> (cnt == W'($past(cnt) + 1'b1)))
    else $error("counter missed a violation");

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP) |=> (cnt == TOP))
    else $error("counter wrapped");
endmodule

// File: rtl/frame_seq_monitor.sv
`timescale 1ns/1ps
module frame_seq_monitor
  import fmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             frm_start_i,
  input  logic             ip_start_i,
  input  logic             pay_start_i,
  input  logic             frm_end_i,
  input  logic             beat_en_i,
  output logic             trig_o,
  output logic [2:0]       trig_code_o,
  output logic [CNT_W-1:0] viol_count_o,
  output logic             frame_open_o
);
  marks_t     marks;
  logic       any_mark, multi_mark, unqualified;
  seq_state_t state;
  viol_t      viol;
  logic       viol_seen;

  assign marks = '{fstart: frm_start_i, ipstart: ip_start_i,
                   pstart: pay_start_i, fend: frm_end_i};

  fmon_qual u_qual (
    .marks(marks), .beat_en(beat_en_i),
    .any_mark(any_mark), .multi_mark(multi_mark), .unqualified(unqualified)
  );

  fmon_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .marks(marks), .beat_en(beat_en_i),
    .any_mark(any_mark), .multi_mark(multi_mark), .unqualified(unqualified),
    .state_o(state), .viol_o(viol)
  );

  assign viol_seen = (viol != V_NONE);

  fmon_trig u_trig (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .viol(viol),
    .trig_o(trig_o), .code_o(trig_code_o)
  );

  fmon_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(viol_seen), .count_o(viol_count_o)
  );

  assign frame_open_o = is_open(state);

  assert_open_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_open_o) |-> $past(frm_start_i && beat_en_i))
    else $error("frame opened without a frame start");

  assert_resync_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESYNC) |=> $stable(viol_count_o))
    else $error("violation counted while resynchronising");

  assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!trig_o && trig_code_o == 3'd0 && !frame_open_o && $stable(viol_count_o)))
    else $error("clear did not release trigger");
endmodule

// File: tb/frame_seq_monitor_test.sv
`timescale 1ns/1ps
module frame_seq_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic fs = 1'b0, ips = 1'b0, ps = 1'b0, fe = 1'b0, be = 1'b0;
  logic        trig;
  logic [2:0]  code;
  logic [15:0] cnt;
  logic        fopen;

  int vectors = 0;
  int fails = 0;

  // reference: 0 none, 1 after start, 2 after ip, 3 in payload, 4 waiting resync
  int m_st = 0, m_trig = 0, m_code = 0, m_cnt = 0;

  always #4 clk = ~clk;

  frame_seq_monitor uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .frm_start_i(fs), .ip_start_i(ips), .pay_start_i(ps), .frm_end_i(fe),
    .beat_en_i(be),
    .trig_o(trig), .trig_code_o(code), .viol_count_o(cnt), .frame_open_o(fopen)
  );

  task automatic model_edge();
    int n, v;
    n = int'(fs) + int'(ips) + int'(ps) + int'(fe);
    v = 0;
    if (clr) begin
      m_st = 0; m_trig = 0; m_code = 0;
    end else if (m_st == 4) begin
      if (fs && be && n == 1) m_st = 1;
    end else if (n > 0) begin
      if (!be) v = 1;
      else if (n > 1) v = 2;
      else if (fs) begin
        if (m_st == 0) m_st = 1; else v = 3;
      end else if (m_st == 0) v = 4;
      else if (ips) begin
        if (m_st == 1) m_st = 2; else v = 7;
      end else if (ps) begin
        if (m_st == 2) m_st = 3; else if (m_st == 3) v = 5; else v = 7;
      end else begin
        if (m_st == 3) m_st = 0; else v = 6;
      end
      if (v != 0) begin
        m_st = 4;
        if (m_cnt < 65535) m_cnt++;
        if (m_trig == 0) begin m_trig = 1; m_code = v; end
      end
    end
  endtask

  task automatic compare(string tag);
    int exp_open;
    exp_open = (m_st >= 1 && m_st <= 3) ? 1 : 0;
    vectors++;
    if (int'(trig) != m_trig || int'(code) != m_code || int'(cnt) != m_cnt ||
        int'(fopen) != exp_open) begin
      fails++;
      $display("FAIL %s t=%0t got trig=%0d code=%0d cnt=%0d open=%0d exp trig=%0d code=%0d cnt=%0d open=%0d",
               tag, $time, trig, code, cnt, fopen, m_trig, m_code, m_cnt, exp_open);
    end
  endtask

  // marks given as {frame start, ip start, payload start, frame end}
  task automatic step(input logic [3:0] mk, input logic b, input logic c, input string tag);
    @(negedge clk);
    {fs, ips, ps, fe} = mk;
    be = b;
    clr = c;
    @(posedge clk);
    #1;
    model_edge();
    compare(tag);
  endtask

  task automatic clear_all(input string tag);
    step(4'b0000, 1'b0, 1'b1, tag);
  endtask

  localparam logic [3:0] F = 4'b1000, I = 4'b0100, P = 4'b0010, E = 4'b0001, Z = 4'b0000;

  initial begin
    #(8 * 195000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    step(Z, 1'b0, 1'b0, "R1");

    // R2: legal frames with idle and data beats
    step(F, 1, 0, "R2"); step(Z, 1, 0, "R2"); step(I, 1, 0, "R2");
    step(Z, 0, 0, "R2"); step(P, 1, 0, "R2"); step(Z, 1, 0, "R2");
    step(Z, 1, 0, "R2"); step(E, 1, 0, "R2");
    step(F, 1, 0, "R2"); step(I, 1, 0, "R2"); step(P, 1, 0, "R2");
    step(E, 1, 0, "R2"); step(Z, 0, 0, "R2");

    // R3: marker without beat enable, takes priority over ordering
    step(F, 1, 0, "R3"); step(F, 0, 0, "R3"); step(Z, 0, 0, "R3"); clear_all("R3");
    // R4: two markers at once
    step(F | I, 1, 0, "R4"); step(Z, 0, 0, "R4"); clear_all("R4");
    // R5: reopen
    step(F, 1, 0, "R5"); step(I, 1, 0, "R5"); step(F, 1, 0, "R5"); clear_all("R5");
    // R6: outside a frame
    step(E, 1, 0, "R6"); clear_all("R6");
    step(P, 1, 0, "R6"); clear_all("R6");
    // R7: duplicate payload start
    step(F, 1, 0, "R7"); step(I, 1, 0, "R7"); step(P, 1, 0, "R7");
    step(Z, 1, 0, "R7"); step(P, 1, 0, "R7"); clear_all("R7");
    // R8: early end
    step(F, 1, 0, "R8"); step(I, 1, 0, "R8"); step(E, 1, 0, "R8"); clear_all("R8");
    // R9: ordering
    step(F, 1, 0, "R9"); step(P, 1, 0, "R9"); clear_all("R9");
    step(F, 1, 0, "R9"); step(I, 1, 0, "R9"); step(I, 1, 0, "R9"); clear_all("R9");
    step(F, 1, 0, "R9"); step(I, 1, 0, "R9"); step(P, 1, 0, "R9");
    step(I, 1, 0, "R9"); clear_all("R9");

    // R10: later violations keep first code
    step(F, 1, 0, "R10"); step(F, 1, 0, "R10");
    step(F, 1, 0, "R10"); step(P, 1, 0, "R10"); step(Z, 0, 0, "R10");

    // R12: junk ignored during resync, then clean restart
    step(E, 1, 0, "R12"); step(P, 1, 0, "R12"); step(F, 0, 0, "R12");
    step(F | E, 1, 0, "R12"); step(I, 0, 0, "R12");
    step(F, 1, 0, "R12"); step(I, 1, 0, "R12"); step(P, 1, 0, "R12");
    step(E, 1, 0, "R12"); step(Z, 0, 0, "R12");

    // R13: clear with a bad marker present
    step(F, 1, 0, "R13"); step(F, 1, 1, "R13"); step(E, 1, 1, "R13");
    step(Z, 0, 0, "R13"); step(F, 1, 0, "R13"); step(E, 1, 0, "R13");
    clear_all("R13");

    // R11: drive into saturation and hold, then clear leaves count
    for (int k = 0; k < 131200; k++) step(F, 1, 0, "R11");
    step(Z, 0, 0, "R11");
    clear_all("R11");
    step(E, 1, 0, "R11");
    step(Z, 0, 0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule